// File: doc/BRIEF.md
# Multi-Channel DMA Sequencer with Packet-Write Abort

This block is a small multi-channel DMA engine. Each channel owns a block of eight word addresses, written by software over a simple write-only register bus, that sets a source base, a destination base, element and frame counts, per-element address steps and per-frame address steps. A channel becomes pending when it receives either a hardware request (if its hardware enable is set) or a software trigger. Pending channels are served one at a time, lowest channel number first. The engine offers one address beat per element on a valid/ready stream. A beat is taken on a cycle with both `xfer_valid` and `xfer_ready` high. While `xfer_ready` is low the offered beat is held unchanged. The one exception is an abort, which withdraws the beat.

The main behaviour is the abort. A bus write that lands on any of the eight words of a pending channel's block counts as an abort, and this includes the two words that hold no data. The abort drops the channel's pending flag and its software enable, and discards its progress. The hardware enable is left as it was. When the channel is triggered again it starts from its first element of its first frame, using the values held in its block at that moment. Software therefore rewrites any word of the block to return a stuck or misbehaving channel to its starting state.

Top module: `dma_pkt_abort`

## Requirements
- R1: Channel c's block occupies byte addresses c*0x20 to c*0x20+0x1C, and only word-aligned writes (bus_addr[1:0]==0) take effect. The words are: +0x00 source base; +0x04 destination base; +0x08 counts, with elements per frame in [15:0] and frames in [31:16]; +0x10 element steps, with source in [15:0] and destination in [31:16]; +0x14 source frame step; +0x18 destination frame step. Writes to +0x0C and +0x1C store nothing.
- R2: The control words sit at 0x80 (NCH*0x20) and above, with bit i of the write data selecting channel i. A write to 0x80 sets hardware enables and a write to 0x84 clears them. A write to 0x88 sets the software enable and the pending flag, both visible in the cycle after the write.
- R3: A `hw_req[i]` pulse sets `pend[i]` in the next cycle only if `hw_en[i]` is already 1. Without the enable the pulse is ignored.
- R4: Each beat of a transfer carries an address pair. The beat for frame f and element e (both counted from 0) has source base + f*source frame step + e*source element step, and the destination follows the same rule. Beats are issued element by element within each frame, and `xfer_last` marks the final beat. A count of 0 behaves as 1.
- R5: While `xfer_valid` is high and `xfer_ready` is low, `xfer_ch`, `xfer_src`, `xfer_dst` and `xfer_last` hold their values. Only an abort can withdraw the beat.
- R6: When several channels are pending and the engine is idle, the lowest-numbered channel is served first. A channel being served runs to completion or abort before any other channel starts.
- R7: In the cycle after the last beat is taken, `done[ch]` is high for exactly one cycle, `pend[ch]` and `sw_en[ch]` are 0, and `hw_en[ch]` is unchanged.
- R8: A write to any word of a pending channel's block, +0x0C and +0x1C included, clears that channel's `pend` and `sw_en` in the next cycle. It leaves `hw_en` unchanged and no further beats of the transfer are issued.
- R9: If the aborting write arrives in the same cycle as an offered beat of that channel, `xfer_valid` is low in that cycle and the beat is not taken.
- R10: After an abort, the next trigger of the channel restarts at frame 0, element 0, and the transfer then runs its full length.
- R11: A write to a channel that is not pending only updates its configuration. The value written last before the trigger is the one used.
- R12: After reset, `pend`, `hw_en`, `sw_en`, `done` and `xfer_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| hw_req | input | NCH | Hardware request pulses, one per channel |
| xfer_valid | output | 1 | Address beat offered |
| xfer_ready | input | 1 | Consumer accepts the beat |
| xfer_ch | output | CH_W | Channel of the offered beat |
| xfer_src | output | 32 | Source address of the beat |
| xfer_dst | output | 32 | Destination address of the beat |
| xfer_last | output | 1 | Final beat of the transfer |
| done | output | NCH | One-cycle completion pulse per channel |
| pend | output | NCH | Pending flags |
| hw_en | output | NCH | Hardware enables |
| sw_en | output | NCH | Software enables |

## Verification
The bench aborts a software-triggered channel in the middle of its second frame through an unused word, and a hardware-triggered channel through the other unused word. A design that decoded only the backed words would carry on issuing beats. A design that kept its counters would resume mid-frame after the retrigger instead of returning to the base addresses. It also checks that the hardware enable survives the abort, so a design that cleared every enable would fail the hardware retrigger. The bench places the aborting write in the same cycle as an offered beat and requires `xfer_valid` to be low, which catches a design that lets the step win that cycle. Further tests cover stalls under back-pressure, zero counts, two simultaneous hardware requests (a wrong arbiter would serve channel 2 first), and garbage written to the unused words of an idle channel, which must not change the transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int STEP_W = 16;

  // Word slot inside a channel block (bus_addr[4:2])
  typedef enum logic [2:0] {
    SLOT_SRC   = 3'd0,
    SLOT_DST   = 3'd1,
    SLOT_CNT   = 3'd2,
    SLOT_GAP_A = 3'd3,
    SLOT_STEP  = 3'd4,
    SLOT_FSRC  = 3'd5,
    SLOT_FDST  = 3'd6,
    SLOT_GAP_B = 3'd7
  } slot_e;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [CNT_W-1:0]  ecnt;
    logic [CNT_W-1:0]  fcnt;
    logic [STEP_W-1:0] sstep;
    logic [STEP_W-1:0] dstep;
    logic [WORD_W-1:0] fsrc;
    logic [WORD_W-1:0] fdst;
  } chan_cfg_t;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8,
  parameter int CH_W   = 2
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NCH-1:0]    sel_bits,
  output logic [NCH-1:0]    blk_hit,
  output dma_pkg::slot_e    slot,
  output logic [NCH-1:0]    hw_set,
  output logic [NCH-1:0]    hw_clr,
  output logic [NCH-1:0]    sw_go
);
  localparam int CTL_BASE = NCH * 32;

  logic              aligned;
  logic              in_ctl;
  logic [CH_W-1:0]   blk_idx;
  logic [ADDR_W-1:0] ctl_ofs;
  logic              ctl_ok;

  always_comb begin
    aligned = (bus_addr[1:0] == 2'b00);
    in_ctl  = (bus_addr >= ADDR_W'(CTL_BASE));
    blk_idx = bus_addr[5 +: CH_W];
    slot    = dma_pkg::slot_e'(bus_addr[4:2]);
    ctl_ofs = bus_addr - ADDR_W'(CTL_BASE);
    ctl_ok  = bus_wr && aligned && in_ctl && (ctl_ofs[ADDR_W-1:4] == '0);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign blk_hit[c] = bus_wr && aligned && !in_ctl && (blk_idx == CH_W'(c));
  end

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    sw_go  = '0;
    if (ctl_ok) begin
      case (ctl_ofs[3:2])
        2'd0:    hw_set = sel_bits;
        2'd1:    hw_clr = sel_bits;
        2'd2:    sw_go  = sel_bits;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_cfg_store.sv
module dma_cfg_store #(
  parameter int NCH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      blk_hit,
  input  dma_pkg::slot_e      slot,
  input  logic [31:0]         wdata,
  output dma_pkg::chan_cfg_t  cfg [NCH]
);
  import dma_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_blk
    chan_cfg_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (blk_hit[c]) begin
        case (slot)
          SLOT_SRC:  r.src <= wdata;
          SLOT_DST:  r.dst <= wdata;
          SLOT_CNT:  {r.fcnt, r.ecnt} <= wdata;
          SLOT_STEP: {r.dstep, r.sstep} <= wdata;
          SLOT_FSRC: r.fsrc <= wdata;
          SLOT_FDST: r.fdst <= wdata;
          default:   ; // gap slots: decoded, nothing kept
        endcase
      end
    end
    assign cfg[c] = r;
  end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] blk_hit,
  input  logic [NCH-1:0] hw_set,
  input  logic [NCH-1:0] hw_clr,
  input  logic [NCH-1:0] sw_go,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] fin,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] hw_en,
  output logic [NCH-1:0] sw_en,
  output logic [NCH-1:0] kill
);

  assign kill = blk_hit & pend;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic trig;
    assign trig = sw_go[c] || (hw_req[c] && hw_en[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[c]  <= 1'b0;
        hw_en[c] <= 1'b0;
        sw_en[c] <= 1'b0;
      end else begin
        if (hw_set[c])      hw_en[c] <= 1'b1;
        else if (hw_clr[c]) hw_en[c] <= 1'b0;

        if (kill[c])        sw_en[c] <= 1'b0;
        else if (sw_go[c])  sw_en[c] <= 1'b1;
        else if (fin[c])    sw_en[c] <= 1'b0;

        if (kill[c])        pend[c] <= 1'b0;
        else if (trig)      pend[c] <= 1'b1;
        else if (fin[c])    pend[c] <= 1'b0;
      end
    end

    a_r8_kill_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
      kill[c] |=> (!pend[c] && !sw_en[c]));
    a_r8_kill_keeps_hw_en: assert property (@(posedge clk) disable iff (!rst_n)
      kill[c] |=> (hw_en[c] == $past(hw_en[c])));
    a_r3_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_req[c] && !hw_en[c] && !pend[c] && !sw_go[c]) |=> !pend[c]);
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     pend,
  input  logic [NCH-1:0]     kill,
  input  dma_pkg::chan_cfg_t cfg [NCH],
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [CH_W-1:0]    xfer_ch,
  output logic [31:0]        xfer_src,
  output logic [31:0]        xfer_dst,
  output logic               xfer_last,
  output logic [NCH-1:0]     fin,
  output logic [NCH-1:0]     done
);
  import dma_pkg::*;

  logic              busy;
  logic [CH_W-1:0]   act;
  logic [31:0]       cur_src, cur_dst, frm_src, frm_dst;
  logic [CNT_W-1:0]  e_left, f_left;
  logic [NCH-1:0]    avail;
  logic              pick_ok;
  logic [CH_W-1:0]   pick;
  logic              kill_act, fire, at_frame_end;
  chan_cfg_t         ac;

  // fixed priority: lowest pending, non-aborted channel
  always_comb begin
    avail   = pend & ~kill;
    pick_ok = |avail;
    pick    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (avail[i]) pick = CH_W'(i);
    end
  end

  always_comb begin
    ac           = cfg[act];
    kill_act     = busy && kill[act];
    xfer_valid   = busy && !kill[act];
    fire         = xfer_valid && xfer_ready;
    at_frame_end = (e_left == CNT_W'(1));
    xfer_last    = at_frame_end && (f_left == CNT_W'(1));
    xfer_ch      = act;
    xfer_src     = cur_src;
    xfer_dst     = cur_dst;
    fin          = '0;
    if (fire && xfer_last) fin[act] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      act     <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      frm_src <= '0;
      frm_dst <= '0;
      e_left  <= '0;
      f_left  <= '0;
      done    <= '0;
    end else begin
      done <= fin;
      if (kill_act) begin
        busy <= 1'b0;
      end else if (fire) begin
        if (xfer_last) begin
          busy <= 1'b0;
        end else if (at_frame_end) begin
          f_left  <= f_left - CNT_W'(1);
          e_left  <= at_least_one(ac.ecnt);
          frm_src <= frm_src + ac.fsrc;
          frm_dst <= frm_dst + ac.fdst;
          cur_src <= frm_src + ac.fsrc;
          cur_dst <= frm_dst + ac.fdst;
        end else begin
          e_left  <= e_left - CNT_W'(1);
          cur_src <= cur_src + {{(32-STEP_W){1'b0}}, ac.sstep};
          cur_dst <= cur_dst + {{(32-STEP_W){1'b0}}, ac.dstep};
        end
      end else if (!busy && pick_ok) begin
        busy    <= 1'b1;
        act     <= pick;
        cur_src <= cfg[pick].src;
        cur_dst <= cfg[pick].dst;
        frm_src <= cfg[pick].src;
        frm_dst <= cfg[pick].dst;
        e_left  <= at_least_one(cfg[pick].ecnt);
        f_left  <= at_least_one(cfg[pick].fcnt);
      end
    end
  end

  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (!xfer_valid ||
      ($stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_ch) && $stable(xfer_last))));
  a_r8_beat_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> pend[xfer_ch]);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> $past(xfer_valid && xfer_ready && xfer_last));

endmodule

// File: rtl/dma_pkt_abort.sv
module dma_pkt_abort #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [NCH-1:0]    hw_req,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [CH_W-1:0]   xfer_ch,
  output logic [31:0]       xfer_src,
  output logic [31:0]       xfer_dst,
  output logic              xfer_last,
  output logic [NCH-1:0]    done,
  output logic [NCH-1:0]    pend,
  output logic [NCH-1:0]    hw_en,
  output logic [NCH-1:0]    sw_en
);
  import dma_pkg::*;

  logic [NCH-1:0] blk_hit, hw_set, hw_clr, sw_go, kill, fin;
  slot_e          slot;
  chan_cfg_t      cfg [NCH];

  dma_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .sel_bits (bus_wdata[NCH-1:0]),
    .blk_hit  (blk_hit),
    .slot     (slot),
    .hw_set   (hw_set),
    .hw_clr   (hw_clr),
    .sw_go    (sw_go)
  );

  dma_cfg_store #(.NCH(NCH)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .blk_hit (blk_hit),
    .slot    (slot),
    .wdata   (bus_wdata),
    .cfg     (cfg)
  );

  dma_chan_ctl #(.NCH(NCH)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .blk_hit (blk_hit),
    .hw_set  (hw_set),
    .hw_clr  (hw_clr),
    .sw_go   (sw_go),
    .hw_req  (hw_req),
    .fin     (fin),
    .pend    (pend),
    .hw_en   (hw_en),
    .sw_en   (sw_en),
    .kill    (kill)
  );

  dma_seq #(.NCH(NCH), .CH_W(CH_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .kill       (kill),
    .cfg        (cfg),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_ch    (xfer_ch),
    .xfer_src   (xfer_src),
    .xfer_dst   (xfer_dst),
    .xfer_last  (xfer_last),
    .fin        (fin),
    .done       (done)
  );

  a_r1_one_block_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blk_hit));
  a_r9_no_step_on_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill && xfer_valid) |-> !kill[xfer_ch]);

endmodule

// File: tb/tb_dma_pkt_abort.sv
`timescale 1ns/1ps
module tb_dma_pkt_abort;
  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam logic [7:0] CTL = 8'h80;

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] ecnt;
    logic [15:0] fcnt;
    logic [15:0] es;
    logic [15:0] ed;
    logic [31:0] fs;
    logic [31:0] fd;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 32'h0000_1000, 32'h0000_2000, 16'd3, 16'd2, 16'd4, 16'd4, 32'h100, 32'h40, 1'b0},
    '{2'd3, 32'hA000_0000, 32'h0000_0010, 16'd2, 16'd3, 16'd8, 16'd0, 32'h20,  32'h4,  1'b1},
    '{2'd1, 32'h0000_0500, 32'h0000_0600, 16'd0, 16'd0, 16'd4, 16'd4, 32'h10,  32'h10, 1'b0},
    '{2'd2, 32'h0000_3000, 32'h0000_4000, 16'd1, 16'd4, 16'd0, 16'd2, 32'h10,  32'h10, 1'b1},
    '{2'd0, 32'h0000_7000, 32'h0000_8000, 16'd4, 16'd1, 16'd2, 16'd1, 32'h0,   32'h0,  1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [NCH-1:0] hw_req = '0;
  logic xfer_ready = 1'b0;
  logic xfer_valid, xfer_last;
  logic [1:0] xfer_ch;
  logic [31:0] xfer_src, xfer_dst;
  logic [NCH-1:0] done, pend, hw_en, sw_en;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_pkt_abort #(.NCH(NCH), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .hw_req(hw_req), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_ch(xfer_ch), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_last(xfer_last), .done(done), .pend(pend),
    .hw_en(hw_en), .sw_en(sw_en)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_hw(input logic [NCH-1:0] m);
    hw_req = m;
    @(posedge clk); @(negedge clk);
    hw_req = '0;
  endtask

  task automatic prog(input vec_t v);
    logic [7:0] b;
    b = {1'b0, v.ch, 5'd0};
    wr(b + 8'h00, v.src);
    wr(b + 8'h04, v.dst);
    wr(b + 8'h08, {v.fcnt, v.ecnt});
    wr(b + 8'h10, {v.ed, v.es});
    wr(b + 8'h14, v.fs);
    wr(b + 8'h18, v.fd);
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    while (!xfer_valid && n < 60) begin
      @(negedge clk); n++;
    end
    chk(xfer_valid, req, {63'd0, xfer_valid}, 64'd1);
  endtask

  task automatic take(input int n);
    for (int k = 0; k < n; k++) begin
      wait_valid("R4");
      xfer_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      xfer_ready = 1'b0;
    end
  endtask

  // full transfer against the address model of R4
  task automatic run_expect(input vec_t v, input string req);
    int ne, nf;
    logic [31:0] es, ed;
    ne = (v.ecnt == 0) ? 1 : int'(v.ecnt);
    nf = (v.fcnt == 0) ? 1 : int'(v.fcnt);
    for (int f = 0; f < nf; f++) begin
      for (int e = 0; e < ne; e++) begin
        es = v.src + 32'(f) * v.fs + 32'(e) * {16'd0, v.es};
        ed = v.dst + 32'(f) * v.fd + 32'(e) * {16'd0, v.ed};
        wait_valid(req);
        if (v.stall) begin
          @(posedge clk); @(negedge clk);
          chk(xfer_valid && xfer_src == es, "R5 held beat", {32'd0, xfer_src}, {32'd0, es});
        end
        chk(xfer_src == es, req, {32'd0, xfer_src}, {32'd0, es});
        chk(xfer_dst == ed, req, {32'd0, xfer_dst}, {32'd0, ed});
        chk(xfer_ch == v.ch, req, {62'd0, xfer_ch}, {62'd0, v.ch});
        chk(xfer_last == (f == nf - 1 && e == ne - 1), "R4 last", {63'd0, xfer_last},
            {63'd0, (f == nf - 1 && e == ne - 1)});
        xfer_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        xfer_ready = 1'b0;
      end
    end
    chk(done[v.ch] && $countones(done) == 1, "R7 done pulse", {60'd0, done}, 64'(1 << v.ch));
    chk(!pend[v.ch] && !sw_en[v.ch], "R7 flags cleared", {60'd0, pend | sw_en}, 64'd0);
    @(negedge clk);
    chk(done == '0, "R7 done one cycle", {60'd0, done}, 64'd0);
  endtask

  initial begin
    vec_t a, b;
    int n;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(pend == 0 && hw_en == 0 && sw_en == 0, "R12 flags", {52'd0, pend, hw_en, sw_en}, 64'd0);
    chk(!xfer_valid && done == 0, "R12 outputs", {59'd0, xfer_valid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of vectors, software triggered (R2, R4, R5, R7)
    for (int i = 0; i < 5; i++) begin
      prog(VECS[i]);
      wr(CTL + 8'h08, 32'(1 << VECS[i].ch));
      chk(sw_en[VECS[i].ch] && pend[VECS[i].ch], "R2 trigger", {60'd0, sw_en}, 64'(1 << VECS[i].ch));
      run_expect(VECS[i], "R4 vector");
    end

    // R1 gap slots and misaligned writes store nothing
    a = VECS[0]; a.ch = 2'd1;
    prog(a);
    wr(8'h2C, 32'hDEAD_BEEF);
    wr(8'h3C, 32'h1234_5678);
    wr(8'h21, 32'hFFFF_FFFF);
    wr(CTL + 8'h08, 32'h2);
    run_expect(a, "R1 gap slots");

    // R11 last write before trigger wins
    a = VECS[2]; a.ch = 2'd2;
    prog(a);
    a.src = 32'h0000_9990;
    wr(8'h40, a.src);
    wr(CTL + 8'h08, 32'h4);
    run_expect(a, "R11 last write");

    // R3 request without enable is ignored
    pulse_hw(4'b0010);
    chk(pend == 0, "R3 no enable", {60'd0, pend}, 64'd0);
    repeat (3) @(negedge clk);
    chk(!xfer_valid, "R3 no beat", {63'd0, xfer_valid}, 64'd0);

    // R8/R9/R10 software channel aborted mid second frame via +0x1C
    a = '{2'd0, 32'h0000_1100, 32'h0000_2200, 16'd4, 16'd3, 16'd4, 16'd4, 32'h100, 32'h100, 1'b0};
    prog(a);
    wr(CTL + 8'h08, 32'h1);
    take(5);
    wait_valid("R9 setup");
    bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h0; xfer_ready = 1'b1;
    #1;
    chk(!xfer_valid, "R9 beat withdrawn", {63'd0, xfer_valid}, 64'd0);
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; xfer_ready = 1'b0;
    chk(!pend[0] && !sw_en[0], "R8 sw abort flags", {62'd0, pend[0], sw_en[0]}, 64'd0);
    repeat (3) @(negedge clk);
    chk(!xfer_valid && done == 0, "R8 no more beats", {59'd0, xfer_valid, done}, 64'd0);
    wr(CTL + 8'h08, 32'h1);
    run_expect(a, "R10 sw restart");

    // R8/R10 hardware channel aborted via +0x0C keeps its enable
    b = '{2'd3, 32'h0000_5000, 32'h0000_6000, 16'd3, 16'd2, 16'd1, 16'd2, 32'h40, 32'h80, 1'b0};
    wr(CTL + 8'h00, 32'h8);
    chk(hw_en == 4'b1000, "R2 hw set", {60'd0, hw_en}, 64'h8);
    prog(b);
    pulse_hw(4'b1000);
    chk(pend[3], "R3 hw pending", {60'd0, pend}, 64'h8);
    take(4);
    wr(8'h6C, 32'hFFFF_FFFF);
    chk(!pend[3] && hw_en[3], "R8 hw abort keeps enable", {60'd0, pend ^ hw_en}, 64'h8);
    repeat (2) @(negedge clk);
    chk(!xfer_valid, "R8 hw stopped", {63'd0, xfer_valid}, 64'd0);
    pulse_hw(4'b1000);
    run_expect(b, "R10 hw restart");
    chk(hw_en[3], "R7 hw enable kept", {60'd0, hw_en}, 64'h8);

    // R6 lowest channel first on simultaneous requests
    wr(CTL + 8'h04, 32'h8);
    wr(CTL + 8'h00, 32'h6);
    chk(hw_en == 4'b0110, "R2 hw clear", {60'd0, hw_en}, 64'h6);
    a = '{2'd1, 32'h0000_0100, 32'h0000_0200, 16'd2, 16'd1, 16'd4, 16'd4, 32'h0, 32'h0, 1'b0};
    b = '{2'd2, 32'h0000_0300, 32'h0000_0400, 16'd2, 16'd1, 16'd4, 16'd4, 32'h0, 32'h0, 1'b1};
    prog(b);
    prog(a);
    pulse_hw(4'b0110);
    chk(pend == 4'b0110, "R6 both pending", {60'd0, pend}, 64'h6);
    run_expect(a, "R6 first ch1");
    run_expect(b, "R6 then ch2");

    n = 0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule